// File: doc/BRIEF.md
# Four-Channel Periodic Event Timer

This block holds four independent 32-bit down-counters that share one clock and are programmed through a small word-addressed register bus. Each channel counts from a programmed reload value down to zero, reloads itself, and latches an event flag. Software picks a period of N clock cycles by writing N-1 as the reload value. A flag raises the channel's interrupt line when that channel's interrupt is enabled. Flags are cleared by writing a one to them.

A block-wide halt bit stops every channel at once and comes out of reset set, so software must clear it before any channel counts. Channel 1 can be stepped by channel 0's zero events rather than by the clock. The pair then acts as one 64-bit counter, with channel 1 as the upper word. A new reload value written while a channel runs takes effect at the next reload. To apply it at once, software turns the channel off and back on.

Top module: `pit_timer`

## Requirements
- R1: The bus uses word addresses. Word 0 bit 0 is the block halt bit. Channel c occupies words 4(c+1) to 4(c+1)+3: reload value, live count (read-only), control, and flag (bit 0). Control bits are 0 = run, 1 = interrupt enable and 2 = chain. After reset the halt bit reads 1, and every other register, every count and every interrupt reads 0.
- R2: A running channel with reload value L reads L, L-1, ... down to 0 on successive clocks. On the clock after it reads 0, it reads L again and its flag is set, which gives an event every L+1 cycles.
- R3: A channel whose run bit becomes effective from the stopped state reads its reload value after the next clock, then counts down from it.
- R4: Writing the reload value while a channel runs leaves the current count sequence unchanged. The new value is used at the next reload.
- R5: Writing control to 0 and then back to run restarts the channel from the reload value it holds at restart time.
- R6: Writing 1 to a flag's bit 0 clears it, and writing 0 leaves it unchanged. If a reload sets the flag in the same cycle as a clear, the flag stays set.
- R7: Each interrupt output equals its channel's flag ANDed with its interrupt enable bit.
- R8: While the halt bit is 1, no count changes. After the halt bit is cleared, every running channel restarts from its reload value on the next clock.
- R9: With channel 1's chain bit set, channel 1 changes only on clocks where channel 0 reloads from zero. Its flag sets only when both counts are zero at that clock.
- R10: The chain bit is stored only for channel 1. On channels 0, 2 and 3 it reads back 0 and has no effect.
- R11: Writing 0 to a channel's control register freezes its count and forces its interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all counting is on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | 6 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at `addr`, combinational |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
Channel 0 is first run free with a short reload value. This shows whether the period is L+1 or L and whether the first count after enabling is the reload value. A reload write in mid-count then separates a deferred load from an immediate one. An off/on toggle and a halt/release show whether each restart takes the latest reload value. Channel 1 is then chained to a 3-cycle channel 0, which separates stepping per clock from stepping per wrap. Finally, channel 2 runs with reload value 0, so its flag sets on every clock; this pins down how a clear that meets a set is resolved. A behavioural model checks the interrupt lines and the addressed word on every clock throughout.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
  localparam int PIT_CH   = 4;
  localparam int PIT_CW   = 32;
  localparam int CHAIN_CH = 1;           // channel that can follow its lower neighbour

  localparam logic [1:0] FLD_LOAD = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_CTRL = 2'd2;
  localparam logic [1:0] FLD_FLAG = 2'd3;

  localparam int CB_RUN   = 0;
  localparam int CB_IE    = 1;
  localparam int CB_CHAIN = 2;

  typedef struct packed {
    logic [PIT_CH-1:0] run;      // channel enabled and block not halted
    logic [PIT_CH-1:0] flagClr;  // write-one-to-clear pulse
    logic              chain;    // upper channel follows lower channel wraps
  } pit_strobe_t;
endpackage

// File: rtl/pit_regs.sv
`timescale 1ns/1ps
module pit_regs
  import pit_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [AW-1:0]                 addr,
  input  logic [PIT_CW-1:0]             wdata,
  input  logic [PIT_CH-1:0][PIT_CW-1:0] count,
  input  logic [PIT_CH-1:0]             flag,
  output logic [PIT_CW-1:0]             rdata,
  output logic [PIT_CH-1:0][PIT_CW-1:0] loadVal,
  output logic [PIT_CH-1:0]             intEn,
  output pit_strobe_t                   strb
);
  localparam int GW = AW - 2;

  logic [GW-1:0]     grp;
  logic [1:0]        fld;
  logic              haltQ;
  logic              chainQ;
  logic [PIT_CH-1:0] runEnQ;

  assign grp = addr[AW-1:2];
  assign fld = addr[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ   <= 1'b1;
      chainQ  <= 1'b0;
      runEnQ  <= '0;
      intEn   <= '0;
      loadVal <= '0;
    end else if (wrEn) begin
      if (grp == '0 && fld == 2'd0) haltQ <= wdata[0];
      for (int c = 0; c < PIT_CH; c++) begin
        if (grp == GW'(c + 1)) begin
          case (fld)
            FLD_LOAD: loadVal[c] <= wdata;
            FLD_CTRL: begin
              runEnQ[c] <= wdata[CB_RUN];
              intEn[c]  <= wdata[CB_IE];
              if (c == CHAIN_CH) chainQ <= wdata[CB_CHAIN];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb.run   = runEnQ & {PIT_CH{~haltQ}};
    strb.chain = chainQ;
    for (int c = 0; c < PIT_CH; c++)
      strb.flagClr[c] = wrEn && (grp == GW'(c + 1)) && (fld == FLD_FLAG) && wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (grp == '0 && fld == 2'd0) rdata[0] = haltQ;
    for (int c = 0; c < PIT_CH; c++) begin
      if (grp == GW'(c + 1)) begin
        case (fld)
          FLD_LOAD: rdata = loadVal[c];
          FLD_CNT:  rdata = count[c];
          FLD_CTRL: begin
            rdata[CB_RUN]   = runEnQ[c];
            rdata[CB_IE]    = intEn[c];
            rdata[CB_CHAIN] = (c == CHAIN_CH) ? chainQ : 1'b0;
          end
          default:  rdata[0] = flag[c];
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_core.sv
`timescale 1ns/1ps
module pit_core
  import pit_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  pit_strobe_t                   strb,
  input  logic [PIT_CH-1:0][PIT_CW-1:0] loadVal,
  output logic [PIT_CH-1:0][PIT_CW-1:0] count,
  output logic [PIT_CH-1:0]             flag
);
  localparam int BASE_CH = CHAIN_CH - 1;

  logic [PIT_CH-1:0] running;
  logic              baseWrap;

  // zero event of the lower channel of the chained pair
  assign baseWrap = strb.run[BASE_CH] & running[BASE_CH] & (count[BASE_CH] == '0);

  for (genvar g = 0; g < PIT_CH; g++) begin : g_ch
    logic              tick;
    logic              wrap;
    logic [PIT_CW-1:0] cntQ;
    logic              runQ;
    logic              flagQ;

    if (g == CHAIN_CH) begin : g_linked
      assign tick = strb.chain ? baseWrap : 1'b1;
    end else begin : g_free
      assign tick = 1'b1;
    end

    assign wrap = strb.run[g] & runQ & tick & (cntQ == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ  <= '0;
        runQ  <= 1'b0;
        flagQ <= 1'b0;
      end else begin
        runQ <= strb.run[g];
        if (strb.run[g] && !runQ)      cntQ <= loadVal[g];
        else if (strb.run[g] && tick)  cntQ <= wrap ? loadVal[g] : cntQ - 1'b1;
        flagQ <= wrap | (flagQ & ~strb.flagClr[g]);
      end
    end

    assign count[g]   = cntQ;
    assign running[g] = runQ;
    assign flag[g]    = flagQ;
  end
endmodule

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer
  import pit_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     addr,
  input  logic [PIT_CW-1:0] wdata,
  output logic [PIT_CW-1:0] rdata,
  output logic [PIT_CH-1:0] irq
);
  pit_strobe_t                   strb;
  logic [PIT_CH-1:0][PIT_CW-1:0] loadVal;
  logic [PIT_CH-1:0][PIT_CW-1:0] count;
  logic [PIT_CH-1:0]             flag;
  logic [PIT_CH-1:0]             intEn;

  pit_regs #(.AW(AW)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .count(count), .flag(flag), .rdata(rdata),
    .loadVal(loadVal), .intEn(intEn), .strb(strb)
  );

  pit_core u_core (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .count(count), .flag(flag)
  );

  assign irq = flag & intEn;
endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk
  import pit_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input pit_strobe_t                   strb,
  input logic [PIT_CH-1:0][PIT_CW-1:0] count,
  input logic [PIT_CH-1:0]             flag
);
  for (genvar i = 0; i < PIT_CH; i++) begin : g_a
    // R8 / R11: a channel that is not allowed to run keeps its count
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strb.run[i] |=> $stable(count[i]));

    // R6: a flag only drops after a write-one clear
    p_flag_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flag[i]) |-> $past(strb.flagClr[i]));

    // R2: a flag only rises from a count of zero
    p_flag_at_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[i]) |-> ($past(count[i]) == '0));
  end

  // R9: chained upper channel holds while the lower one is not at zero
  p_chain_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.chain && $past(strb.run[CHAIN_CH]) && strb.run[CHAIN_CH]
      && count[CHAIN_CH-1] != '0) |=> $stable(count[CHAIN_CH]));
endmodule

bind pit_timer pit_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .count(count), .flag(flag)
);

// File: tb/pit_timer_test.sv
`timescale 1ns/1ps
module pit_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";
  logic [31:0] v1, v2;

  pit_timer uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // behavioural reference state
  int unsigned mLoad [4];
  int unsigned mCnt  [4];
  bit mTen [4], mTie [4], mRun [4], mFlag [4];
  bit mChain = 0, mHalt = 1;

  initial for (int i = 0; i < 4; i++) begin
    mLoad[i] = 0; mCnt[i] = 0; mTen[i] = 0; mTie[i] = 0; mRun[i] = 0; mFlag[i] = 0;
  end

  always @(posedge clk) begin
    bit act [4];
    bit wr0;
    bit tk;
    bit wrp;
    bit clr;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        mLoad[i] = 0; mCnt[i] = 0; mTen[i] = 0; mTie[i] = 0; mRun[i] = 0; mFlag[i] = 0;
      end
      mChain = 0; mHalt = 1;
    end else begin
      wr0 = mTen[0] && !mHalt && mRun[0] && mCnt[0] == 0;
      for (int i = 0; i < 4; i++) begin
        act[i] = mTen[i] && !mHalt;
        tk  = (i == 1 && mChain) ? wr0 : 1'b1;
        wrp = act[i] && mRun[i] && tk && mCnt[i] == 0;
        clr = wrEn && addr == 6'((i + 1) * 4 + 3) && wdata[0];
        if (act[i] && !mRun[i])  mCnt[i] = mLoad[i];
        else if (act[i] && tk)   mCnt[i] = wrp ? mLoad[i] : mCnt[i] - 1;
        mRun[i]  = act[i];
        mFlag[i] = wrp || (mFlag[i] && !clr);
      end
      if (wrEn) begin
        if (addr == 6'd0) mHalt = wdata[0];
        for (int i = 0; i < 4; i++) begin
          if (addr == 6'((i + 1) * 4))     mLoad[i] = wdata;
          if (addr == 6'((i + 1) * 4 + 2)) begin
            mTen[i] = wdata[0]; mTie[i] = wdata[1];
            if (i == 1) mChain = wdata[2];
          end
        end
      end
    end
  end

  function automatic logic [31:0] mRead(input logic [5:0] a);
    int g;
    int c;
    g = int'(a[5:2]);
    if (a == 6'd0) return {31'd0, mHalt};
    if (g < 1 || g > 4) return '0;
    c = g - 1;
    case (a[1:0])
      2'd0: return mLoad[c];
      2'd1: return mCnt[c];
      2'd2: return {29'd0, (c == 1) ? mChain : 1'b0, mTie[c], mTen[c]};
      default: return {31'd0, mFlag[c]};
    endcase
  endfunction

  function automatic logic [3:0] mIrq();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = mFlag[i] && mTie[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, {28'd0, irq}, {28'd0, mIrq()});
      chk(curReq, rdata, mRead(addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    // R1: reset state
    rd(6'd0, v1);  chk("R1", v1, 32'd1);
    rd(6'd5, v1);  chk("R1", v1, 32'd0);
    chk("R1", {28'd0, irq}, 32'd0);
    wr(6'd0, 32'd0);

    // R3: start from stopped loads the reload value next clock
    curReq = "R3";
    wr(6'd4, 32'd9);
    wr(6'd6, 32'd1);
    step(1); rd(6'd5, v1); chk("R3", v1, 32'd9);
    step(1); rd(6'd5, v1); chk("R3", v1, 32'd8);

    // R2: count to zero then reload and set flag
    curReq = "R2";
    step(8); rd(6'd5, v1); chk("R2", v1, 32'd0);
    step(1); rd(6'd5, v1); chk("R2", v1, 32'd9);
    rd(6'd7, v1); chk("R2", v1, 32'd1);
    chk("R7", {31'd0, irq[0]}, 32'd0);

    // R7: enabling the interrupt exposes the pending flag
    curReq = "R7";
    wr(6'd6, 32'd3);
    chk("R7", {31'd0, irq[0]}, 32'd1);

    // R6: write 0 keeps, write 1 clears
    curReq = "R6";
    wr(6'd7, 32'd0);
    rd(6'd7, v1); chk("R6", v1, 32'd1);
    wr(6'd7, 32'd1);
    rd(6'd7, v1); chk("R6", v1, 32'd0);
    chk("R6", {31'd0, irq[0]}, 32'd0);

    // R4: reload write mid-cycle is deferred
    curReq = "R4";
    wr(6'd4, 32'd20);
    rd(6'd5, v1); chk("R4", v1, 32'd1);
    step(1); rd(6'd5, v1); chk("R4", v1, 32'd0);
    step(1); rd(6'd5, v1); chk("R4", v1, 32'd20);

    // R5: off/on restarts from the latest reload value
    curReq = "R5";
    step(3);
    wr(6'd4, 32'd30);
    wr(6'd6, 32'd0);
    wr(6'd6, 32'd3);
    step(1); rd(6'd5, v1); chk("R5", v1, 32'd30);

    // R11: writing 0 freezes and masks
    curReq = "R11";
    wr(6'd6, 32'd0);
    rd(6'd5, v1);
    step(5);
    rd(6'd5, v2); chk("R11", v2, v1);
    chk("R11", {31'd0, irq[0]}, 32'd0);

    // R8: block halt freezes, release restarts from reload
    curReq = "R8";
    wr(6'd6, 32'd1);
    step(4);
    wr(6'd0, 32'd1);
    rd(6'd5, v1);
    step(4);
    rd(6'd5, v2); chk("R8", v2, v1);
    rd(6'd0, v2); chk("R8", v2, 32'd1);
    wr(6'd0, 32'd0);
    step(1); rd(6'd5, v1); chk("R8", v1, 32'd30);
    wr(6'd6, 32'd0);

    // R9: chained pair
    curReq = "R9";
    wr(6'd4, 32'd2);
    wr(6'd8, 32'd1);
    wr(6'd10, 32'd7);
    rd(6'd10, v1); chk("R9", v1, 32'd7);
    wr(6'd6, 32'd1);
    step(4);
    rd(6'd9, v1);  chk("R9", v1, 32'd0);
    rd(6'd11, v1); chk("R9", v1, 32'd0);
    step(3);
    rd(6'd9, v1);  chk("R9", v1, 32'd1);
    rd(6'd11, v1); chk("R9", v1, 32'd1);
    chk("R9", {31'd0, irq[1]}, 32'd1);
    step(12);

    // R10: chain bit not kept on other channels
    curReq = "R10";
    wr(6'd14, 32'd7);
    rd(6'd14, v1); chk("R10", v1, 32'd3);
    step(3);

    // R6: clear meets a set in the same cycle (reload value 0 wraps every clock)
    curReq = "R6";
    wr(6'd15, 32'd1);
    rd(6'd15, v1); chk("R6", v1, 32'd1);

    curReq = "R11";
    wr(6'd6, 32'd0);
    wr(6'd10, 32'd0);
    wr(6'd14, 32'd0);
    wr(6'd7, 32'd1);
    wr(6'd11, 32'd1);
    wr(6'd15, 32'd1);
    step(4);
    chk("R11", {28'd0, irq}, 32'd0);

    summary();
    $finish;
  end
endmodule